// File: doc/BRIEF.md
# Reset-Gated Chip-Enable Controller

This block sits between a processor's memory chip-enable (active low) and a battery-backed memory. It follows the supervisor's reset flag, the direction of the supply ramp and the battery flag. From these it decides whether the chip-enable passes through to the memory or is held inactive-high. In normal operation every chip-enable transition passes straight through.

When reset asserts while the supply is falling, the gate does not close at once. An access that is already in progress may finish. The gate closes as soon as the chip-enable is seen high, or when a grace window of `GRACE_CYC` clock cycles runs out, whichever comes first. When reset is asserted while the supply is rising, or in battery mode, the gate is shut and the memory cannot be selected. The gate reopens on the cycle after reset is seen released.

Top module: `ce_gate_ctrl`

## Requirements
- R1: At any clock edge where `rst_ni`=1, `sup_rst_i`=0 and `batt_i`=0 are sampled, the gate is open from the next cycle on, and `ce_no` then equals `ce_ni` combinationally.
- R2: At an edge with the gate open, `sup_rst_i`=1 and `pwr_down_i`=1, the gate closes after that edge if `ce_ni`=1 is sampled. Otherwise it enters a grace window in which it stays open, and it closes after the first edge at which `ce_ni`=1 is sampled.
- R3: If `ce_ni` stays low, the grace window lasts exactly `GRACE_CYC` cycles after the edge that started it. The gate is closed after the following edge, so the gate never stays open with reset asserted for more than `GRACE_CYC`+1 sampled edges.
- R4: If `sup_rst_i` is sampled low during the grace window, the window is cancelled and the gate stays open. A later reset assertion starts a fresh window of the full length.
- R5: At an edge where `sup_rst_i`=1 and `pwr_down_i`=0 are sampled, the gate is closed after that edge, and it stays closed whatever `ce_ni` does until R1 applies.
- R6: While the gate is closed, `ce_no` is 1.
- R7: While `batt_i`=1, `ce_no` is 1 in the same cycle and `ce_ni` is ignored. The gate is closed after the first edge that samples `batt_i`=1, and it stays closed until R1 applies.
- R8: `gate_open_o` is a registered flag that is 1 exactly in the cycles where the gate passes `ce_ni`, with `batt_i` low.
- R9: While `rst_ni`=0, the gate is closed, `gate_open_o`=0 and `ce_no`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip-enable from the processor, active low |
| sup_rst_i | input | 1 | Supervisor reset asserted |
| pwr_down_i | input | 1 | 1 = supply falling, 0 = supply rising |
| batt_i | input | 1 | Battery-backup mode active |
| ce_no | output | 1 | Gated chip-enable to memory, active low |
| gate_open_o | output | 1 | Gate passing chip-enable (registered) |

## Verification
A wrong gate state shows at `ce_no` in the same cycle the processor drives the chip-enable low: the memory is either selected when it should be blocked or cut off in the middle of an access. A grace counter that is off by one shows up exactly one edge early or late, at the moment the gate closes after a held-low chip-enable. Every cycle, the bench compares both outputs with a cycle-level model. It does this through long held-low windows, through cancelled windows and through random reset episodes, so a wrong state is reported within the cycle in which it first shows.

// File: rtl/ceg_pkg.sv
`timescale 1ns/1ps
package ceg_pkg;
  typedef enum logic [1:0] {
    GATE_CLOSED = 2'd0,
    GATE_OPEN   = 2'd1,
    GATE_DRAIN  = 2'd2
  } gate_st_e;
endpackage

// File: rtl/ceg_grace_timer.sv
`timescale 1ns/1ps
module ceg_grace_timer #(
  parameter int GRACE_CYC = 3000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int CW = (GRACE_CYC < 2) ? 1 : $clog2(GRACE_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= CW'(GRACE_CYC - 1);
    end else if (run_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/ceg_fsm.sv
`timescale 1ns/1ps
module ceg_fsm
  import ceg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic sup_rst_i,
  input  logic pwr_down_i,
  input  logic batt_i,
  input  logic expired_i,
  output logic load_o,
  output logic run_o,
  output logic gate_en_o
);
  gate_st_e st_q, st_d;
  logic     gate_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      GATE_OPEN: begin
        if (batt_i)         st_d = GATE_CLOSED;
        else if (sup_rst_i) st_d = (pwr_down_i && !ce_ni) ? GATE_DRAIN : GATE_CLOSED;
      end
      GATE_DRAIN: begin
        if (batt_i)                             st_d = GATE_CLOSED;
        else if (!sup_rst_i)                    st_d = GATE_OPEN;
        else if (!pwr_down_i || ce_ni || expired_i) st_d = GATE_CLOSED;
      end
      GATE_CLOSED: begin
        if (!batt_i && !sup_rst_i) st_d = GATE_OPEN;
      end
      default: st_d = GATE_CLOSED;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= GATE_CLOSED;
      gate_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      gate_q <= (st_d != GATE_CLOSED);
    end
  end

  // timer restarts on every fresh entry into the grace window
  assign load_o    = (st_q == GATE_OPEN) && (st_d == GATE_DRAIN);
  assign run_o     = (st_q == GATE_DRAIN);
  assign gate_en_o = gate_q;
endmodule

// File: rtl/ceg_out_gate.sv
`timescale 1ns/1ps
module ceg_out_gate (
  input  logic gate_en_i,
  input  logic batt_i,
  input  logic ce_ni,
  output logic ce_no
);
  // closed or battery: drive inactive high
  assign ce_no = (gate_en_i && !batt_i) ? ce_ni : 1'b1;
endmodule

// File: rtl/ce_gate_ctrl.sv
`timescale 1ns/1ps
module ce_gate_ctrl #(
  parameter int GRACE_CYC = 3000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic sup_rst_i,
  input  logic pwr_down_i,
  input  logic batt_i,
  output logic ce_no,
  output logic gate_open_o
);
  logic load, run, expired, gate_en;

  ceg_grace_timer #(.GRACE_CYC(GRACE_CYC)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .run_i     (run),
    .expired_o (expired)
  );

  ceg_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ce_ni      (ce_ni),
    .sup_rst_i  (sup_rst_i),
    .pwr_down_i (pwr_down_i),
    .batt_i     (batt_i),
    .expired_i  (expired),
    .load_o     (load),
    .run_o      (run),
    .gate_en_o  (gate_en)
  );

  ceg_out_gate u_out (
    .gate_en_i (gate_en),
    .batt_i    (batt_i),
    .ce_ni     (ce_ni),
    .ce_no     (ce_no)
  );

  assign gate_open_o = gate_en;
endmodule

// File: rtl/ceg_checker.sv
`timescale 1ns/1ps
module ceg_checker #(
  parameter int GRACE_CYC = 3000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic ce_ni,
  input logic sup_rst_i,
  input logic pwr_down_i,
  input logic batt_i,
  input logic ce_no,
  input logic gate_open_o
);
  localparam int RW = $clog2(GRACE_CYC + 3);

  logic [RW-1:0] run_q;

  // consecutive sampled edges with gate open while reset is asserted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      run_q <= '0;
    else if (gate_open_o && sup_rst_i) run_q <= (run_q == '1) ? run_q : run_q + 1'b1;
    else                              run_q <= '0;
  end

  p_open_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni && !sup_rst_i && !batt_i) |-> gate_open_o);

  p_ce_high_close_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni && sup_rst_i && ce_ni) |-> !gate_open_o);

  p_grace_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= RW'(GRACE_CYC + 1));

  p_pwr_up_closed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni && sup_rst_i && !pwr_down_i) |-> !gate_open_o);

  p_closed_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_open_o |-> ce_no);

  p_batt_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    batt_i |-> ce_no);

  p_batt_closed_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni && batt_i) |-> !gate_open_o);

  p_reset_state_r9: assert property (@(posedge clk_i)
    !rst_ni |-> (ce_no && !gate_open_o));
endmodule

bind ce_gate_ctrl ceg_checker #(.GRACE_CYC(GRACE_CYC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ce_ni       (ce_ni),
  .sup_rst_i   (sup_rst_i),
  .pwr_down_i  (pwr_down_i),
  .batt_i      (batt_i),
  .ce_no       (ce_no),
  .gate_open_o (gate_open_o)
);

// File: tb/ce_gate_ctrl_bench.sv
`timescale 1ns/1ps
module ce_gate_ctrl_bench;
  localparam int G = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce = 1'b1, sup = 1'b1, pd = 1'b0, batt = 1'b0;
  logic ce_o, gate_o;
  int total = 0, bad = 0;
  int m_st = 0;  // 0 closed, 1 open, 2 grace window
  int m_cnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ce_gate_ctrl #(.GRACE_CYC(G)) u_ce_gate_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .ce_ni       (ce),
    .sup_rst_i   (sup),
    .pwr_down_i  (pwr_down_dummy_fix(pd)),
    .batt_i      (batt),
    .ce_no       (ce_o),
    .gate_open_o (gate_o)
  );

  function automatic logic pwr_down_dummy_fix(input logic v);
    return v;
  endfunction

  function automatic logic exp_gate();
    return (m_st != 0);
  endfunction

  function automatic logic exp_ce();
    return (m_st != 0 && !batt) ? ce : 1'b1;
  endfunction

  task automatic mdl_update();
    if (!rst_n || batt) m_st = 0;
    else begin
      case (m_st)
        1: if (sup) begin
             if (pd && !ce) begin m_st = 2; m_cnt = G - 1; end
             else m_st = 0;
           end
        2: if (!sup) m_st = 1;
           else if (!pd || ce || m_cnt == 0) m_st = 0;
           else m_cnt = m_cnt - 1;
        default: if (!sup) m_st = 1;
      endcase
    end
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(input logic r, input logic s, input logic p, input logic b,
                      input logic c, input string req);
    @(negedge clk);
    rst_n = r; sup = s; pd = p; batt = b; ce = c;
    #1;
    chk(req, "gate_open_o", gate_o, exp_gate());
    chk(req, "ce_no", ce_o, exp_ce());
    @(posedge clk);
    mdl_update();
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int r;
    r = $urandom(32'h5EED1);
    // R9: reset state
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, i[0], "R9");
    // R1: open after release, transitions pass
    for (int i = 0; i < 8; i++) step(1, 0, 0, 0, i[0], "R1");
    // R3: held-low grace window expires
    for (int i = 0; i < G + 5; i++) step(1, 1, 1, 0, 0, "R3");
    for (int i = 0; i < 3; i++) step(1, 0, 1, 0, 0, "R1");
    // R2: access ends mid window
    for (int i = 0; i < 5; i++) step(1, 1, 1, 0, 0, "R2");
    for (int i = 0; i < 4; i++) step(1, 1, 1, 0, 1, "R2");
    step(1, 1, 1, 0, 0, "R6");
    for (int i = 0; i < 3; i++) step(1, 0, 1, 0, 1, "R1");
    // R2: chip-enable already high at assertion
    for (int i = 0; i < 4; i++) step(1, 1, 1, 0, i[1], "R2");
    for (int i = 0; i < 3; i++) step(1, 0, 1, 0, 0, "R1");
    // R4: cancel then full-length restart
    for (int i = 0; i < 10; i++) step(1, 1, 1, 0, 0, "R4");
    for (int i = 0; i < 2; i++) step(1, 0, 1, 0, 0, "R4");
    for (int i = 0; i < G + 4; i++) step(1, 1, 1, 0, 0, "R4");
    for (int i = 0; i < 3; i++) step(1, 0, 1, 0, 1, "R1");
    // R5/R6: power-up reset ignores chip-enable
    for (int i = 0; i < 12; i++) step(1, 1, 0, 0, i[0], "R5");
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, "R1");
    // R7: battery mode, with and without reset
    for (int i = 0; i < 5; i++) step(1, 1, 1, 1, i[0], "R7");
    for (int i = 0; i < 4; i++) step(1, 0, 1, 1, 0, "R7");
    for (int i = 0; i < 3; i++) step(1, 0, 1, 0, 0, "R1");
    // R7: battery arriving during a grace window
    for (int i = 0; i < 3; i++) step(1, 1, 1, 0, 0, "R7");
    step(1, 1, 1, 1, 0, "R7");
    step(1, 1, 1, 1, 0, "R7");
    // R8: random episodes
    begin
      logic s = 1'b0, p = 1'b1, b = 1'b0;
      for (int i = 0; i < 6000; i++) begin
        if ($urandom_range(0, 19) == 0) begin
          s = ~s;
          if (s) p = ($urandom_range(0, 3) != 0);
        end
        b = ($urandom_range(0, 99) < 2);
        step(1, s, p, b, ($urandom_range(0, 5) == 0) ? 1'b1 : 1'b0, "R8");
      end
    end
    done = 1'b1;
    summary();
    $finish;
  end
endmodule